// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel with a byte-wide host port, a GATE input and an OUT output. The host first writes a control byte that selects one of six counting behaviours, then writes the initial count as two bytes, low byte first. From then on the channel decrements once per clock. Depending on the selected behaviour, OUT acts as a terminal-count flag, a retriggerable one-shot, a divide-by-N tick, a square wave, or a one-clock strobe fired by software or by a GATE edge.

The host can read the live count two bytes at a time. It can also issue a freeze command, so that both bytes come from one instant. A status command captures the OUT level and the programmed mode code for the next read. Everything runs on the one clock. GATE is sampled on that clock, and a rising edge means low on the previous edge and high on the current one.

Top module: `pit_channel`

## Requirements
- R1: A control byte (sel_ctrl=1) with bits [5:4]=11 programs the channel, and its bits [3:1] give the mode code. Codes 6 and 7 behave exactly as codes 2 and 3. Bits [5:4]=00 is the freeze command and 10 is the status command.
- R2: Count bytes (sel_ctrl=0) are written low byte then high byte, and the high byte starts the load. A programming byte returns both the write and the read byte pointers to the low byte. A count of 0 means 65536.
- R3: Mode 0: programming drives OUT low and OUT stays low after the load. OUT goes high after exactly N counting clocks and stays high until the channel is reprogrammed or reloaded.
- R4: Mode 1: OUT stays high after the load until a GATE rising edge, which drives OUT low for N clocks. A further rising edge while OUT is low restarts the N-clock interval.
- R5: Mode 2: OUT is low for one clock every N clocks, first low N clocks after the load, with N >= 2.
- R6: Mode 3: OUT is high for ceil(N/2) clocks and low for floor(N/2) clocks, repeating, with N >= 2.
- R7: Mode 4: OUT stays high after the load, goes low for exactly one clock N clocks after the load, then stays high.
- R8: Mode 5: nothing counts until a GATE rising edge. N clocks after that edge OUT is low for one clock. Each later rising edge starts the sequence again.
- R9: In modes 0, 2, 3 and 4, a low GATE holds the count. Counting resumes from the held value when GATE returns high.
- R10: After a freeze command, the next low-byte and high-byte reads both return the count as it stood at the command, even while counting continues. Reading the high byte releases the freeze.
- R11: After a status command, the next data read returns {OUT, 3'b000, mode code[2:0], 1'b0} and does not move the read byte pointer.
- R12: After reset OUT is high, the count is 0 and the first data read returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| sel_ctrl | input | 1 | 1 selects the control byte, 0 the count data |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte (count byte or status) |
| gate | input | 1 | Gate: enables counting or triggers, depending on mode |
| out | output | 1 | Timer output |

## Verification
The bench targets the off-by-one edges of each mode. It checks OUT on every clock against a model of the cycle on which it must change, so a design that reloads one clock late, or holds a strobe for two clocks, shows up as a wrong OUT level. Odd N in mode 3 catches a design that gives the extra clock to the low half. Codes 6 and 7 catch a mode decoder that does not fold the top bit. A one-shot retriggered mid-interval must still be low where an unretriggered one would have risen. A count of zero must take 65536 clocks and not expire at once. A freeze followed by ten counting clocks must still read the old value. A stray low byte before reprogramming would load a wrong count if the byte pointer were not cleared.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CW = 16;          // counter width
    localparam int VW = CW + 1;      // width able to hold 2**CW
    localparam int BW = 8;           // host byte width

    typedef enum logic [2:0] {
        M_TC_FLAG  = 3'd0,
        M_ONESHOT  = 3'd1,
        M_DIVIDER  = 3'd2,
        M_SQUARE   = 3'd3,
        M_SW_STB   = 3'd4,
        M_HW_STB   = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'b00,
        ACC_NONE   = 2'b01,
        ACC_STATUS = 2'b10,
        ACC_PROG   = 2'b11
    } acc_e;

    // codes x1x fold onto 2 and 3
    function automatic mode_e fold_mode(input logic [2:0] code);
        if (code[1]) return mode_e'({1'b0, code[1:0]});
        return mode_e'(code);
    endfunction

    // zero count stands for 2**CW
    function automatic logic [VW-1:0] span(input logic [CW-1:0] n);
        if (n == '0) return {1'b1, {CW{1'b0}}};
        return {1'b0, n};
    endfunction

    function automatic logic [VW-1:0] half_hi(input logic [VW-1:0] v);
        return (v + VW'(1)) >> 1;
    endfunction

    function automatic logic [VW-1:0] half_lo(input logic [VW-1:0] v);
        return v >> 1;
    endfunction
endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic gate_rise
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b1;
        else     gate_q <= gate;
    end

    assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/pit_bus_if.sv
module pit_bus_if
    import pit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          sel_ctrl,
    input  logic [BW-1:0] wdata,
    input  logic [CW-1:0] cnt_now,
    input  logic          out_now,
    output logic          prog,
    output mode_e         prog_mode,
    output mode_e         mode,
    output logic          load,
    output logic [CW-1:0] init_val,
    output logic [BW-1:0] rdata
);
    logic [2:0]    code_q;
    logic          wr_hi, rd_hi;
    logic [BW-1:0] lo_q;
    logic          frozen;
    logic [CW-1:0] frz_val;
    logic          stat_pend;
    logic [BW-1:0] stat_val;
    acc_e          acc;
    logic          ctl_wr, dat_wr, dat_rd;
    logic [CW-1:0] src;

    assign acc       = acc_e'(wdata[5:4]);
    assign ctl_wr    = wr_en & sel_ctrl;
    assign dat_wr    = wr_en & ~sel_ctrl;
    assign dat_rd    = rd_en & ~sel_ctrl;
    assign prog      = ctl_wr && (acc == ACC_PROG);
    assign prog_mode = fold_mode(wdata[3:1]);
    assign mode      = fold_mode(code_q);
    assign load      = dat_wr & wr_hi;
    assign init_val  = {wdata, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q    <= '0;
            wr_hi     <= 1'b0;
            rd_hi     <= 1'b0;
            lo_q      <= '0;
            frozen    <= 1'b0;
            frz_val   <= '0;
            stat_pend <= 1'b0;
            stat_val  <= '0;
        end else begin
            if (ctl_wr) begin
                case (acc)
                    ACC_PROG: begin
                        code_q <= wdata[3:1];
                        wr_hi  <= 1'b0;
                        rd_hi  <= 1'b0;
                    end
                    ACC_FREEZE: if (!frozen) begin
                        frozen  <= 1'b1;
                        frz_val <= cnt_now;
                    end
                    ACC_STATUS: begin
                        stat_pend <= 1'b1;
                        stat_val  <= {out_now, 3'b000, code_q, 1'b0};
                    end
                    default: ;
                endcase
            end
            if (dat_wr) begin
                if (!wr_hi) lo_q <= wdata;
                wr_hi <= ~wr_hi;
            end
            if (dat_rd) begin
                if (stat_pend) stat_pend <= 1'b0;
                else begin
                    rd_hi <= ~rd_hi;
                    if (rd_hi && frozen) frozen <= 1'b0;
                end
            end
        end
    end

    assign src   = frozen ? frz_val : cnt_now;
    assign rdata = stat_pend ? stat_val : (rd_hi ? src[CW-1:BW] : src[BW-1:0]);

    p_freeze_release_r10: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && !stat_pend && rd_hi && frozen && !ctl_wr) |=> !frozen);
    p_freeze_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (frozen && $past(frozen)) |-> $stable(frz_val));
    p_ptr_clear_r2: assert property (@(posedge clk) disable iff (rst)
        prog |=> (!wr_hi && !rd_hi));
    p_status_keep_ptr_r11: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && stat_pend && !prog) |=> $stable(rd_hi));
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          prog,
    input  mode_e         prog_mode,
    input  mode_e         mode,
    input  logic          load,
    input  logic [CW-1:0] init_val,
    input  logic          gate,
    input  logic          gate_rise,
    output logic [CW-1:0] cnt_out,
    output logic          out
);
    localparam logic [VW-1:0] ONE = VW'(1);

    logic [VW-1:0] cnt, reload;
    logic          run, armed, strobe;
    logic          trig_mode, enable;
    logic [VW-1:0] nval;

    assign nval      = span(init_val);
    assign trig_mode = (mode == M_ONESHOT) || (mode == M_HW_STB);
    assign enable    = run && (gate || trig_mode);
    assign cnt_out   = cnt[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            reload <= '0;
            run    <= 1'b0;
            armed  <= 1'b0;
            strobe <= 1'b0;
            out    <= 1'b1;
        end else if (prog) begin
            run    <= 1'b0;
            armed  <= 1'b0;
            strobe <= 1'b0;
            out    <= (prog_mode != M_TC_FLAG);
        end else if (load) begin
            reload <= nval;
            armed  <= 1'b1;
            strobe <= 1'b0;
            out    <= (mode != M_TC_FLAG);
            run    <= !trig_mode;
            if (mode == M_SQUARE) cnt <= half_hi(nval);
            else if (!trig_mode)  cnt <= nval;
        end else begin
            if (strobe) begin
                out    <= 1'b1;
                strobe <= 1'b0;
            end
            if (trig_mode && armed && gate_rise) begin
                cnt <= reload;
                run <= 1'b1;
                out <= (mode != M_ONESHOT);
            end else if (enable) begin
                if (cnt == ONE) begin
                    case (mode)
                        M_DIVIDER: begin
                            cnt    <= reload;
                            out    <= 1'b0;
                            strobe <= 1'b1;
                        end
                        M_SQUARE: begin
                            out <= ~out;
                            cnt <= out ? half_lo(reload) : half_hi(reload);
                        end
                        M_SW_STB, M_HW_STB: begin
                            cnt    <= '0;
                            run    <= 1'b0;
                            out    <= 1'b0;
                            strobe <= 1'b1;
                        end
                        default: begin
                            cnt <= '0;
                            run <= 1'b0;
                            out <= 1'b1;
                        end
                    endcase
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    p_tc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == M_TC_FLAG && out && !run && !prog && !load) |=> out);
    p_strobe_width_r7: assert property (@(posedge clk) disable iff (rst)
        ((mode == M_SW_STB || mode == M_HW_STB) && !out && $past(out) && !prog) |=> out);
    p_gate_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !gate && !trig_mode && !prog && !load) |=> $stable(cnt));
    p_oneshot_low_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ONESHOT && run && !prog && !load) |-> !out);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          sel_ctrl,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    input  logic          gate,
    output logic          out
);
    logic          prog, load, gate_rise;
    mode_e         prog_mode, mode;
    logic [CW-1:0] init_val, cnt_now;

    pit_gate_edge u_gate (
        .clk(clk), .rst(rst), .gate(gate), .gate_rise(gate_rise)
    );

    pit_bus_if u_bus (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .sel_ctrl(sel_ctrl), .wdata(wdata), .cnt_now(cnt_now),
        .out_now(out), .prog(prog), .prog_mode(prog_mode), .mode(mode),
        .load(load), .init_val(init_val), .rdata(rdata)
    );

    pit_count_core u_core (
        .clk(clk), .rst(rst), .prog(prog), .prog_mode(prog_mode),
        .mode(mode), .load(load), .init_val(init_val), .gate(gate),
        .gate_rise(gate_rise), .cnt_out(cnt_now), .out(out)
    );
endmodule

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, sel_ctrl = 1'b0, gate = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       out;
    int         n_tests = 0, n_fail = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    pit_channel u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel_ctrl(sel_ctrl),
        .wdata(wdata), .rdata(rdata), .gate(gate), .out(out)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; sel_ctrl = c; wdata = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1; sel_ctrl = 1'b0; #1 b = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // expected OUT j clocks after the load edge
    function automatic logic exp_out(input int code, input int n, input int j);
        int m = (code[1]) ? (code & 3) : code;
        case (m)
            0: return j >= n;
            2: return !(j > 0 && (j % n) == 0);
            3: return (j % n) < ((n + 1) / 2);
            default: return j != n;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] b, b2;
        int codes [6] = '{0, 2, 3, 4, 6, 7};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk({7'b0, out}, 8'h01, "R12 out after reset");
        rd(b);
        chk(b, 8'h00, "R12 count after reset");

        // R2 pointer cleared by programming byte
        gate = 1'b1;
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h77);
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h00);
        chk({7'b0, out}, 8'h00, "R2/R3 low after load");
        repeat (2) @(negedge clk);
        chk({7'b0, out}, 8'h00, "R2 low at N-1");
        @(negedge clk);
        chk({7'b0, out}, 8'h01, "R2 high at N=3 after stray byte");

        // R9 / R10 gate hold and freeze
        gate = 1'b0;
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h34);
        wr(1'b0, 8'h12);
        repeat (3) @(negedge clk);
        rd(b); rd(b2);
        chk(b, 8'h34, "R9 held low byte");
        chk(b2, 8'h12, "R9 held high byte");
        wr(1'b1, 8'h00);
        @(negedge clk); gate = 1'b1;
        repeat (10) @(negedge clk);
        gate = 1'b0;
        rd(b); rd(b2);
        chk(b, 8'h34, "R10 frozen low byte");
        chk(b2, 8'h12, "R10 frozen high byte");
        rd(b); rd(b2);
        chk(b, 8'h2A, "R9 resumed low byte");
        chk(b2, 8'h12, "R9 resumed high byte");
        chk({7'b0, out}, 8'h00, "R3 still low while held");

        // R1/R5/R6/R7/R3 randomized modes, checked each clock
        gate = 1'b1;
        for (int it = 0; it < 24; it++) begin
            int code = codes[$urandom % 6];
            int n = 2 + ($urandom % 29);
            wr(1'b1, 8'h30 | 8'(code << 1));
            wr(1'b0, 8'(n));
            wr(1'b0, 8'h00);
            for (int j = 0; j <= 2 * n + 3; j++) begin
                if (j > 0) @(negedge clk);
                if (exp_out(code, n, j) !== out) begin
                    n_tests++; n_fail++;
                    $display("FAIL R1/R3/R5/R6/R7 code %0d N %0d j %0d: got %0b expected %0b",
                             code, n, j, out, exp_out(code, n, j));
                end else n_tests++;
            end
        end

        // R4 retriggerable one-shot, N=4
        gate = 1'b0;
        wr(1'b1, 8'h32);
        wr(1'b0, 8'h04);
        wr(1'b0, 8'h00);
        repeat (3) @(negedge clk);
        chk({7'b0, out}, 8'h01, "R4 high before trigger");
        gate = 1'b1;                       // rise at T
        @(negedge clk);
        chk({7'b0, out}, 8'h00, "R4 low after trigger");
        gate = 1'b0;
        @(negedge clk); gate = 1'b1;       // rise at T+2
        @(negedge clk);
        chk({7'b0, out}, 8'h00, "R4 low after retrigger");
        @(negedge clk); @(negedge clk);
        chk({7'b0, out}, 8'h00, "R4 still low at T+4");
        @(negedge clk);
        chk({7'b0, out}, 8'h00, "R4 still low at T+5");
        @(negedge clk);
        chk({7'b0, out}, 8'h01, "R4 high at T+6");

        // R8 hardware strobe, N=3
        gate = 1'b0;
        wr(1'b1, 8'h3A);
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h00);
        repeat (6) @(negedge clk);
        chk({7'b0, out}, 8'h01, "R8 idle before edge");
        for (int k = 0; k < 2; k++) begin
            gate = 1'b1;
            @(negedge clk);
            chk({7'b0, out}, 8'h01, "R8 high after edge");
            @(negedge clk); @(negedge clk);
            chk({7'b0, out}, 8'h01, "R8 high at N-1");
            @(negedge clk);
            chk({7'b0, out}, 8'h00, "R8 strobe at N");
            @(negedge clk);
            chk({7'b0, out}, 8'h01, "R8 strobe one clock");
            gate = 1'b0;
            repeat (3) @(negedge clk);
            chk({7'b0, out}, 8'h01, "R8 waits for next edge");
        end

        // R2 zero count = 65536, then R11 status
        gate = 1'b1;
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h00);
        repeat (65535) @(negedge clk);
        chk({7'b0, out}, 8'h00, "R2 zero count low at 65535");
        @(negedge clk);
        chk({7'b0, out}, 8'h01, "R2 zero count high at 65536");
        wr(1'b1, 8'h20);
        rd(b);
        chk(b, 8'h80, "R11 status mode 0 high");
        wr(1'b1, 8'h38);
        wr(1'b1, 8'h20);
        rd(b);
        chk(b, 8'h88, "R11 status mode 4");
        wr(1'b1, 8'h3C);
        wr(1'b1, 8'h20);
        rd(b);
        chk(b, 8'h8C, "R1/R11 status code 6");

        done = 1'b1;
        summary();
    end
endmodule